// File: doc/BRIEF.md
# Boot Address Remap Unit

This block turns a bus address aimed at the zero-based boot window into a byte offset inside the flash array. Two remap channels are kept, one for the hard processor and one for a soft processor built in the fabric. Each channel has its own base-offset register and its own enable. Both channels share one segment-size code, and that code sets how large the boot window is.

Requests arrive on a valid/ready stream that carries the master identity and the address. The block answers one cycle after it accepts a request, on a registered valid/ready output that carries the flash offset and a hit flag. A request is accepted on a rising edge only when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output payload holds. The configuration registers use a plain write port and a combinational read port. A separate flag reports a size code that selects no segment size.

Top module: `boot_remap_unit`

## Requirements
- R1: After reset the size register reads 18 (0x12), both base registers read 0, and `cfg_err` is 0.
- R2: The register select encoding is 0 = size, 1 = hard-processor base, 2 = fabric base, 3 = none. A base register keeps write data bits [18:0]: bits [18:1] are the byte offset bits [18:1] and bit 0 is the enable. Read bits [31:19] are 0, and select 3 reads 0 and stores nothing.
- R3: With the selected channel's enable clear, the offset equals address bits [18:0], which is the bottom of the flash.
- R4: With the enable set and a valid size code, the offset equals the base plus (address AND (segment size − 1)), taken modulo 2^19.
- R5: Master 0 uses the hard-processor base and enable. Master 1 uses the fabric base and enable, independently of master 0.
- R6: Size codes 13 to 18 select 16, 32, 64, 128, 256 and 512 KB, so the size is 2^(code+1) bytes. `out_hit` is 1 exactly when the address is below the window size.
- R7: A size code outside 13..18 drives `cfg_err` to 1, turns remapping off for both channels (offset = address bits [18:0]), and sets the window to 512 KB.
- R8: `in_ready` = !out_valid || out_ready. An accepted request appears on the output one cycle later. While `out_valid` is high and `out_ready` is low, the output stays valid and stable.
- R9: Writes to the size register keep only bits [4:0]; reads return those bits with bits [31:5] at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Register read data (combinational) |
| cfg_err | output | 1 | Size code selects no segment size |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle |
| in_master | input | 1 | 0 = hard processor, 1 = fabric processor |
| in_addr | input | 32 | Address into the boot window |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_offset | output | 19 | Flash byte offset |
| out_hit | output | 1 | Address lies inside the boot window |

## Verification
The bench builds the block with its default parameters: a 32-bit address bus, a 19-bit flash offset and two channels. With these values every size code from 13 to 18 can be reached, and so can the wrap of base plus masked address at the 512 KB boundary. Reserved codes on both sides of the valid range and window-edge addresses for the small and middle segments are also covered. Back-pressure is exercised by holding `out_ready` low while a second request waits.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_W      = 32;
  localparam int FLASH_AW   = 19;
  localparam int CODE_W     = 5;
  localparam int CODE_LO    = 13;
  localparam int CODE_HI    = 18;
  localparam int LOG2_AT_LO = 14;
  localparam int CODE_RST   = 18;
  localparam int NCH        = 2;

  typedef enum logic [1:0] {
    SEL_SIZE = 2'd0,
    SEL_HARD = 2'd1,
    SEL_FAB  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/remap_size_decode.sv
module remap_size_decode
  import remap_pkg::*;
#(
  parameter int CW  = CODE_W,
  parameter int FAW = FLASH_AW
) (
  input  logic [CW-1:0]  code,
  output logic [FAW-1:0] mask,
  output logic           code_ok
);
  localparam int SHIFT = LOG2_AT_LO - CODE_LO;

  int unsigned lg;

  always_comb begin
    code_ok = (int'(code) >= CODE_LO) && (int'(code) <= CODE_HI);
    lg      = code_ok ? (int'(code) + SHIFT) : FAW;
    mask    = '0;
    for (int b = 0; b < FAW; b++) begin
      mask[b] = (b < lg);
    end
  end
endmodule

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int FAW = FLASH_AW,
  parameter int CW  = CODE_W,
  parameter int NC  = NCH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [RW-1:0]       wr_data,
  input  logic [1:0]          rd_sel,
  output logic [RW-1:0]       rd_data,
  output logic [CW-1:0]       size_code,
  output logic [NC-1:0][FAW-1:0] base_off,
  output logic [NC-1:0]       base_en
);
  logic [FAW-1:0] base_q [NC];

  logic unused_wr_hi;
  assign unused_wr_hi = &{1'b0, wr_data[RW-1:FAW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_code <= CW'(CODE_RST);
    end else if (wr_en && reg_sel_e'(wr_sel) == SEL_SIZE) begin
      size_code <= wr_data[CW-1:0];
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[c] <= '0;
      end else if (wr_en && int'(wr_sel) == c + 1) begin
        base_q[c] <= wr_data[FAW-1:0];
      end
    end
    assign base_off[c] = {base_q[c][FAW-1:1], 1'b0};
    assign base_en[c]  = base_q[c][0];
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_SIZE: rd_data = RW'(size_code);
      SEL_HARD: rd_data = RW'(base_q[0]);
      SEL_FAB:  rd_data = RW'(base_q[NC-1]);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int AW  = REG_W,
  parameter int FAW = FLASH_AW
) (
  input  logic [AW-1:0]  addr,
  input  logic [FAW-1:0] base,
  input  logic           en,
  input  logic [FAW-1:0] mask,
  input  logic           code_ok,
  output logic [FAW-1:0] offset,
  output logic           hit
);
  logic [FAW-1:0] low;
  logic           active;

  assign low    = addr[FAW-1:0];
  assign active = en && code_ok;
  assign offset = active ? (base + (low & mask)) : low;
  assign hit    = (addr[AW-1:FAW] == '0) && ((low & ~mask) == '0);
endmodule

// File: rtl/boot_remap_unit.sv
module boot_remap_unit
  import remap_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int FAW = FLASH_AW,
  parameter int CW  = CODE_W,
  parameter int NC  = NCH,
  localparam int MW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [RW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [RW-1:0] rd_data,
  output logic          cfg_err,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [MW-1:0] in_master,
  input  logic [RW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FAW-1:0] out_offset,
  output logic          out_hit
);
  logic [CW-1:0]          size_code;
  logic [NC-1:0][FAW-1:0] base_off;
  logic [NC-1:0]          base_en;
  logic [FAW-1:0]         mask;
  logic                   code_ok;
  logic [NC-1:0][FAW-1:0] ch_off;
  logic [NC-1:0]          ch_hit;
  logic [FAW-1:0]         sel_off;
  logic                   sel_hit;

  remap_cfg_regs #(.RW(RW), .FAW(FAW), .CW(CW), .NC(NC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .size_code(size_code), .base_off(base_off), .base_en(base_en)
  );

  remap_size_decode #(.CW(CW), .FAW(FAW)) u_size (
    .code(size_code), .mask(mask), .code_ok(code_ok)
  );

  for (genvar c = 0; c < NC; c++) begin : g_ch
    remap_xlate #(.AW(RW), .FAW(FAW)) u_xl (
      .addr(in_addr), .base(base_off[c]), .en(base_en[c]),
      .mask(mask), .code_ok(code_ok),
      .offset(ch_off[c]), .hit(ch_hit[c])
    );
  end

  always_comb begin
    sel_off = ch_off[0];
    sel_hit = ch_hit[0];
    for (int c = 1; c < NC; c++) begin
      if (int'(in_master) == c) begin
        sel_off = ch_off[c];
        sel_hit = ch_hit[c];
      end
    end
  end

  assign cfg_err  = !code_ok;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_hit    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_offset <= sel_off;
        out_hit    <= sel_hit;
      end
    end
  end
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int FAW = FLASH_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] rd_data,
  input logic          cfg_err,
  input logic          in_valid,
  input logic          in_ready,
  input logic [RW-1:0] in_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [FAW-1:0] out_offset,
  input logic          out_hit
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_hit));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && cfg_err |=> out_offset == $past(in_addr[FAW-1:0]));

  p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_addr[RW-1:FAW] != '0) |=> !out_hit);

  p_rd_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RW-1:FAW] == '0);
endmodule

bind boot_remap_unit remap_checker #(.RW(RW), .FAW(FAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .cfg_err(cfg_err),
  .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_offset(out_offset), .out_hit(out_hit)
);

// File: tb/sim_boot_remap_unit.sv
module sim_boot_remap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        cfg_err;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [0:0]  in_master = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [18:0] out_offset;
  logic        out_hit;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  boot_remap_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_master(in_master), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .out_hit(out_hit)
  );

  typedef struct packed {
    logic [4:0]  code;
    logic        mst;
    logic [31:0] hreg;
    logic [31:0] freg;
    logic [31:0] addr;
    logic [18:0] off;
    logic        hit;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd18, 1'b0, 32'h00000, 32'h00000, 32'h00001234, 19'h01234, 1'b1, 1'b0, 8'd3},
    '{5'd18, 1'b0, 32'h40001, 32'h00000, 32'h00001234, 19'h41234, 1'b1, 1'b0, 8'd4},
    '{5'd13, 1'b0, 32'h40001, 32'h00000, 32'h00005ABC, 19'h41ABC, 1'b0, 1'b0, 8'd6},
    '{5'd13, 1'b0, 32'h40001, 32'h00000, 32'h00003FFF, 19'h43FFF, 1'b1, 1'b0, 8'd6},
    '{5'd15, 1'b1, 32'h40001, 32'h20001, 32'h00000100, 19'h20100, 1'b1, 1'b0, 8'd5},
    '{5'd15, 1'b1, 32'h40001, 32'h20000, 32'h00000100, 19'h00100, 1'b1, 1'b0, 8'd5},
    '{5'd16, 1'b0, 32'h7C001, 32'h00000, 32'h0001FFFF, 19'h1BFFF, 1'b1, 1'b0, 8'd4},
    '{5'd12, 1'b0, 32'h40001, 32'h00000, 32'h00001234, 19'h01234, 1'b1, 1'b1, 8'd7},
    '{5'd19, 1'b1, 32'h00000, 32'h20001, 32'h00090000, 19'h10000, 1'b0, 1'b1, 8'd7},
    '{5'd17, 1'b0, 32'h00001, 32'h00000, 32'h00040000, 19'h00000, 1'b0, 1'b0, 8'd6},
    '{5'd14, 1'b1, 32'h00000, 32'h00003, 32'h00000010, 19'h00012, 1'b1, 1'b0, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic send(input logic m, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_master = m; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 size reset", 2'd0, 32'h12);
    rd_chk("R1 hard base reset", 2'd1, 32'h0);
    rd_chk("R1 fabric base reset", 2'd2, 32'h0);
    chk("R1 cfg_err reset", {31'b0, cfg_err}, 32'h0);
    chk("R8 idle out_valid", {31'b0, out_valid}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 tagged per entry
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      wr(2'd0, {27'b0, VECS[i].code});
      wr(2'd1, VECS[i].hreg);
      wr(2'd2, VECS[i].freg);
      send(VECS[i].mst, VECS[i].addr);
      chk({tg, " valid"}, {31'b0, out_valid}, 32'h1);
      chk({tg, " offset"}, {13'b0, out_offset}, {13'b0, VECS[i].off});
      chk({tg, " hit"}, {31'b0, out_hit}, {31'b0, VECS[i].hit});
      chk({tg, " err"}, {31'b0, cfg_err}, {31'b0, VECS[i].err});
    end

    // R2 base register upper bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk("R2 hard base masked", 2'd1, 32'h0007_FFFF);
    wr(2'd2, 32'hABCD_0004);
    rd_chk("R2 fabric base masked", 2'd2, 32'h0005_0004);
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk("R2 select 3 reads zero", 2'd3, 32'h0);
    rd_chk("R2 select 3 leaves hard base", 2'd1, 32'h0007_FFFF);
    rd_chk("R2 select 3 leaves fabric base", 2'd2, 32'h0005_0004);
    rd_chk("R2 select 3 leaves size", 2'd0, 32'h0E);

    // R9 size register keeps [4:0]
    wr(2'd0, 32'hFFFF_FFED);
    rd_chk("R9 size masked", 2'd0, 32'h0D);
    chk("R9 cfg_err with code 13", {31'b0, cfg_err}, 32'h0);

    // R8 back-pressure
    wr(2'd0, 32'd18);
    wr(2'd1, 32'h0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_master = 1'b0; in_addr = 32'h10;
    @(negedge clk);
    chk("R8 first accepted", {31'b0, out_valid}, 32'h1);
    chk("R8 first offset", {13'b0, out_offset}, 32'h10);
    in_addr = 32'h20;
    #1;
    chk("R8 in_ready low under stall", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    chk("R8 held valid", {31'b0, out_valid}, 32'h1);
    chk("R8 held offset", {13'b0, out_offset}, 32'h10);
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready on drain", {31'b0, in_ready}, 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second offset", {13'b0, out_offset}, 32'h20);
    chk("R8 second valid", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    chk("R8 drained", {31'b0, out_valid}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule